// File: doc/BRIEF.md
# Prefix-Aware Register Operand Decoder

This block sits in the decode stage of an 8-bit processor. It takes one instruction byte per valid cycle and resolves two opcode groups. The first is the register-to-register load group, opcodes 0x40 to 0x7F. The second is the accumulator arithmetic and logic group, opcodes 0x80 to 0xBF. For each decoded byte it reports:

- the destination register select and the source register select;
- whether a memory operand is involved;
- whether a displacement byte must be fetched;
- which ALU operation applies.

Two index-prefix bytes, 0xDD and 0xFD, are absorbed and held in an internal latch. While a prefix is held, the H and L operands are redirected to the high and low halves of the first or second index register. When a memory operand is present, the memory address comes from that index register plus a displacement. In that case the other operand stays the plain H or L register.

Opcode 0x76 would otherwise be a load from memory to memory. It is decoded as a halt request instead, and it sets a halted flag that only reset clears. A prefix byte that arrives while a prefix is already held ends the pending instruction as a lone prefix, which is reported as a no-operation. The new prefix byte becomes the one held. Register storage, bus cycles and address arithmetic belong to neighbouring blocks.

Top module: `opdec_core`

## Requirements
- R1: After reset `halted` is 0 and no prefix is held, so the first opcode decodes unprefixed.
- R2: For opcodes 0x40–0x7F other than 0x76, `ld_en` is 1, `dst_sel` comes from bits 5:3 and `src_sel` from bits 2:0. Field code n maps to select code n in the order B=0, C=1, D=2, E=3, H=4, L=5, memory=6, A=7.
- R3: A field value of 6 yields select code 6 (memory) and sets `mem_op`. With no prefix held, `need_disp` is 0.
- R4: Opcode 0x76, with or without a prefix, gives `halt_req`=1 and `ld_en`=0. `halted` is 1 from the next cycle and stays 1 until reset.
- R5: With prefix 0xDD held and no memory operand, H maps to select 8 and L to select 9. With 0xFD held, H maps to 10 and L to 11.
- R6: Under a prefix, when one operand is memory, the other H/L operand keeps select 4 or 5, and `need_disp` is 1.
- R7: For opcodes 0x80–0xBF, `alu_en` is 1, `dst_sel` is 7 (A) and `src_sel` is mapped from bits 2:0 as in R2, R3 and R5. `alu_op` equals bits 5:3: add=0, add-with-carry=1, subtract=2, subtract-with-borrow=3, and=4, xor=5, or=6, compare=7.
- R8: A prefix byte received while a prefix is held gives `lone_prefix`=1 and no decode. The new byte's prefix is then held for the next opcode.
- R9: A prefix byte received with none held gives `pfx_taken`=1 and no decode. The held prefix is cleared by every valid non-prefix byte.
- R10: Any other opcode gives `other_op`=1, selects 0, `alu_op` 0, and all other flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction byte is present this cycle |
| in_byte | input | 8 | Instruction byte |
| ld_en | output | 1 | Register load group decoded |
| alu_en | output | 1 | Accumulator ALU group decoded |
| halt_req | output | 1 | Halt opcode decoded |
| halted | output | 1 | Sticky halted flag |
| lone_prefix | output | 1 | Repeated prefix ended the instruction as a no-op |
| pfx_taken | output | 1 | Prefix byte absorbed |
| other_op | output | 1 | Opcode outside the decoded groups |
| mem_op | output | 1 | An operand is the memory operand |
| need_disp | output | 1 | Memory operand needs a displacement byte |
| dst_sel | output | 4 | Destination register select |
| src_sel | output | 4 | Source register select |
| alu_op | output | 3 | ALU operation code |

## Verification
The block has no width parameters worth varying, so the bench builds it at its only configuration, with prefix codes 0xDD and 0xFD. That makes a full sweep affordable: every one of the 256 opcodes under each of the three prefix states. The sweep reaches every memory/H/L interaction, the halt carve-out under prefixes, and every repeated-prefix pairing. Directed sequences then cover the sticky halt flag across reset and the prefix clearing after a completed instruction.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
    localparam int BYTE_W = 8;
    localparam int FLD_W  = 3;
    localparam int SEL_W  = 4;
    localparam int ALU_W  = 3;

    localparam logic [BYTE_W-1:0] CODE_PFX_IX = 8'hDD;
    localparam logic [BYTE_W-1:0] CODE_PFX_IY = 8'hFD;
    localparam logic [BYTE_W-1:0] CODE_HALT   = 8'h76;

    localparam logic [1:0] GRP_LOAD = 2'b01;
    localparam logic [1:0] GRP_ALU  = 2'b10;

    localparam logic [FLD_W-1:0] FLD_HI  = 3'd4;
    localparam logic [FLD_W-1:0] FLD_LO  = 3'd5;
    localparam logic [FLD_W-1:0] FLD_MEM = 3'd6;

    typedef enum logic [1:0] {
        PX_NONE = 2'd0,
        PX_IX   = 2'd1,
        PX_IY   = 2'd2
    } pfx_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_B   = 4'd0,
        SEL_C   = 4'd1,
        SEL_D   = 4'd2,
        SEL_E   = 4'd3,
        SEL_H   = 4'd4,
        SEL_L   = 4'd5,
        SEL_MEM = 4'd6,
        SEL_A   = 4'd7,
        SEL_IXH = 4'd8,
        SEL_IXL = 4'd9,
        SEL_IYH = 4'd10,
        SEL_IYL = 4'd11
    } regsel_e;

    typedef enum logic [ALU_W-1:0] {
        ALU_ADD = 3'd0,
        ALU_ADC = 3'd1,
        ALU_SUB = 3'd2,
        ALU_SBC = 3'd3,
        ALU_AND = 3'd4,
        ALU_XOR = 3'd5,
        ALU_OR  = 3'd6,
        ALU_CP  = 3'd7
    } aluop_e;

    typedef struct packed {
        logic    ld;
        logic    alu;
        logic    hreq;
        logic    other;
        logic    mem;
        logic    disp;
        regsel_e dst;
        regsel_e src;
        aluop_e  op;
    } decode_t;

    function automatic logic is_prefix(input logic [BYTE_W-1:0] b);
        return (b == CODE_PFX_IX) || (b == CODE_PFX_IY);
    endfunction

    function automatic pfx_e prefix_kind(input logic [BYTE_W-1:0] b);
        if (b == CODE_PFX_IX) return PX_IX;
        if (b == CODE_PFX_IY) return PX_IY;
        return PX_NONE;
    endfunction
endpackage

// File: rtl/opdec_prefix_tracker.sv
module opdec_prefix_tracker
    import opdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output pfx_e              pfx_q,
    output logic              pfx_byte,
    output logic              lone
);
    assign pfx_byte = in_valid && is_prefix(in_byte);
    assign lone     = pfx_byte && (pfx_q != PX_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pfx_q <= PX_NONE;
        end else if (in_valid) begin
            // a prefix byte arms the latch; any other byte completes an instruction
            pfx_q <= pfx_byte ? prefix_kind(in_byte) : PX_NONE;
        end
    end
endmodule

// File: rtl/opdec_operand_map.sv
module opdec_operand_map
    import opdec_pkg::*;
(
    input  logic [FLD_W-1:0] fld,
    input  pfx_e             pfx,
    input  logic             partner_mem,
    output regsel_e          sel
);
    logic redirect;
    assign redirect = (pfx != PX_NONE) && !partner_mem;

    always_comb begin
        sel = regsel_e'({1'b0, fld});
        if (redirect && fld == FLD_HI)
            sel = (pfx == PX_IX) ? SEL_IXH : SEL_IYH;
        else if (redirect && fld == FLD_LO)
            sel = (pfx == PX_IX) ? SEL_IXL : SEL_IYL;
    end
endmodule

// File: rtl/opdec_halt_keeper.sv
module opdec_halt_keeper (
    input  logic clk,
    input  logic rst,
    input  logic set,
    output logic halted
);
    always_ff @(posedge clk) begin
        if (rst)      halted <= 1'b0;
        else if (set) halted <= 1'b1;
    end
endmodule

// File: rtl/opdec_core.sv
module opdec_core
    import opdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              ld_en,
    output logic              alu_en,
    output logic              halt_req,
    output logic              halted,
    output logic              lone_prefix,
    output logic              pfx_taken,
    output logic              other_op,
    output logic              mem_op,
    output logic              need_disp,
    output logic [SEL_W-1:0]  dst_sel,
    output logic [SEL_W-1:0]  src_sel,
    output logic [ALU_W-1:0]  alu_op
);
    pfx_e    pfx_q;
    logic    pfx_byte;
    logic    lone;
    regsel_e dst_map;
    regsel_e src_map;
    decode_t dec;

    logic [FLD_W-1:0] f_hi;
    logic [FLD_W-1:0] f_lo;
    logic [1:0]       grp;
    logic             dv;
    logic             is_halt;
    logic             grp_ld;
    logic             grp_alu;

    assign f_hi    = in_byte[5:3];
    assign f_lo    = in_byte[2:0];
    assign grp     = in_byte[7:6];
    assign dv      = in_valid && !pfx_byte;
    assign is_halt = (in_byte == CODE_HALT);
    assign grp_ld  = dv && (grp == GRP_LOAD) && !is_halt;
    assign grp_alu = dv && (grp == GRP_ALU);

    opdec_prefix_tracker u_pfx (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .pfx_q    (pfx_q),
        .pfx_byte (pfx_byte),
        .lone     (lone)
    );

    opdec_operand_map u_dst (
        .fld         (f_hi),
        .pfx         (pfx_q),
        .partner_mem (f_lo == FLD_MEM),
        .sel         (dst_map)
    );

    // the accumulator is the partner in the ALU group, never memory
    opdec_operand_map u_src (
        .fld         (f_lo),
        .pfx         (pfx_q),
        .partner_mem (grp_ld && (f_hi == FLD_MEM)),
        .sel         (src_map)
    );

    always_comb begin
        dec       = '0;
        dec.ld    = grp_ld;
        dec.alu   = grp_alu;
        dec.hreq  = dv && is_halt;
        dec.other = dv && !grp_ld && !grp_alu && !is_halt;
        if (grp_ld) begin
            dec.dst = dst_map;
            dec.src = src_map;
            dec.mem = (f_hi == FLD_MEM) || (f_lo == FLD_MEM);
        end else if (grp_alu) begin
            dec.dst = SEL_A;
            dec.src = src_map;
            dec.mem = (f_lo == FLD_MEM);
            dec.op  = aluop_e'(f_hi);
        end
        dec.disp = dec.mem && (pfx_q != PX_NONE);
    end

    opdec_halt_keeper u_halt (
        .clk    (clk),
        .rst    (rst),
        .set    (dec.hreq),
        .halted (halted)
    );

    assign ld_en       = dec.ld;
    assign alu_en      = dec.alu;
    assign halt_req    = dec.hreq;
    assign other_op    = dec.other;
    assign mem_op      = dec.mem;
    assign need_disp   = dec.disp;
    assign dst_sel     = dec.dst;
    assign src_sel     = dec.src;
    assign alu_op      = dec.op;
    assign lone_prefix = lone;
    assign pfx_taken   = pfx_byte && !lone;
endmodule

// File: rtl/opdec_checker.sv
module opdec_checker (
    input logic       clk,
    input logic       rst,
    input logic       ld_en,
    input logic       alu_en,
    input logic       halt_req,
    input logic       halted,
    input logic       lone_prefix,
    input logic       pfx_taken,
    input logic       mem_op,
    input logic       need_disp,
    input logic [3:0] dst_sel,
    input logic [3:0] src_sel
);
    // R4: halted only rises after a halt request
    p_halt_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) |-> $past(halt_req));

    // R4: halted is sticky until reset
    p_halt_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R3 / R6: a displacement is only requested for a memory operand
    p_disp_mem_r6: assert property (@(posedge clk) disable iff (rst)
        need_disp |-> mem_op);

    // R4: the load group never yields memory on both sides
    p_no_mem_mem_r4: assert property (@(posedge clk) disable iff (rst)
        ld_en |-> !(dst_sel == 4'd6 && src_sel == 4'd6));

    // R7: ALU group always targets the accumulator
    p_alu_dst_a_r7: assert property (@(posedge clk) disable iff (rst)
        alu_en |-> dst_sel == 4'd7);

    // R5 / R6: index halves never appear alongside a memory operand
    p_index_no_mem_r6: assert property (@(posedge clk) disable iff (rst)
        ((ld_en || alu_en) && (dst_sel >= 4'd8 || src_sel >= 4'd8)) |-> !mem_op);

    // R8 / R9: prefix bytes decode nothing
    p_prefix_silent_r8: assert property (@(posedge clk) disable iff (rst)
        (lone_prefix || pfx_taken) |-> !(ld_en || alu_en || halt_req));

    // R8: at most one of the prefix outcomes per byte
    p_prefix_excl_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lone_prefix, pfx_taken}));
endmodule

bind opdec_core opdec_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .ld_en       (ld_en),
    .alu_en      (alu_en),
    .halt_req    (halt_req),
    .halted      (halted),
    .lone_prefix (lone_prefix),
    .pfx_taken   (pfx_taken),
    .mem_op      (mem_op),
    .need_disp   (need_disp),
    .dst_sel     (dst_sel),
    .src_sel     (src_sel)
);

// File: tb/tb_opdec_core.sv
module tb_opdec_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic ld_en, alu_en, halt_req, halted, lone_prefix, pfx_taken, other_op;
    logic mem_op, need_disp;
    logic [3:0] dst_sel, src_sel;
    logic [2:0] alu_op;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    opdec_core dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .ld_en(ld_en), .alu_en(alu_en), .halt_req(halt_req), .halted(halted),
        .lone_prefix(lone_prefix), .pfx_taken(pfx_taken), .other_op(other_op),
        .mem_op(mem_op), .need_disp(need_disp), .dst_sel(dst_sel),
        .src_sel(src_sel), .alu_op(alu_op)
    );

    // flags: ld alu hreq lone ptk other mem disp | dst | src | op  (19 bits)
    function automatic logic [18:0] observed();
        return {ld_en, alu_en, halt_req, lone_prefix, pfx_taken, other_op,
                mem_op, need_disp, dst_sel, src_sel, alu_op};
    endfunction

    // p: 0 none, 1 = 0xDD held, 2 = 0xFD held
    function automatic logic [3:0] map_fld(int f, int p, bit partner_mem);
        if (p != 0 && !partner_mem && f == 4) return (p == 1) ? 4'd8 : 4'd10;
        if (p != 0 && !partner_mem && f == 5) return (p == 1) ? 4'd9 : 4'd11;
        return 4'(f);
    endfunction

    function automatic logic [18:0] expect_of(int p, int op);
        logic [18:0] e = '0;
        int hi = (op / 8) % 8;
        int lo = op % 8;
        bit m;
        if (op == 8'hDD || op == 8'hFD) begin
            e[15] = (p != 0);
            e[14] = (p == 0);
        end else if (op == 8'h76) begin
            e[16] = 1'b1;
        end else if (op >= 8'h40 && op < 8'h80) begin
            m = (hi == 6) || (lo == 6);
            e[18] = 1'b1;
            e[12] = m;
            e[11] = m && (p != 0);
            e[10:7] = map_fld(hi, p, lo == 6);
            e[6:3]  = map_fld(lo, p, hi == 6);
        end else if (op >= 8'h80 && op < 8'hC0) begin
            m = (lo == 6);
            e[17] = 1'b1;
            e[12] = m;
            e[11] = m && (p != 0);
            e[10:7] = 4'd7;
            e[6:3]  = map_fld(lo, p, 1'b0);
            e[2:0]  = 3'(hi);
        end else begin
            e[13] = 1'b1;
        end
        return e;
    endfunction

    function automatic string tag_of(int op);
        if (op == 8'hDD || op == 8'hFD) return "R8";
        if (op == 8'h76) return "R4";
        if (op >= 8'h40 && op < 8'h80) return "R2/R3/R5/R6";
        if (op >= 8'h80 && op < 8'hC0) return "R7";
        return "R10";
    endfunction

    task automatic chk(string tag, logic [18:0] act, logic [18:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
        end
    endtask

    task automatic chk1(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // drive at negedge, settle, caller samples before the next posedge
    task automatic put(logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'h00;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    initial begin
        do_reset();
        // R1: reset state
        chk1("R1 halted after reset", halted, 1'b0);
        put(8'h64);
        chk("R1 first opcode unprefixed", observed(), expect_of(0, 8'h64));

        // R9: prefix then plain opcode, then prefix cleared
        put(8'hDD);
        chk("R9 prefix absorbed", observed(), expect_of(0, 8'hDD));
        put(8'h65);
        chk("R5 IX halves", observed(), expect_of(1, 8'h65));
        put(8'h65);
        chk("R9 prefix cleared after instruction", observed(), expect_of(0, 8'h65));

        // R6: mem with H under FD prefix
        put(8'hFD);
        put(8'h74);
        chk("R6 plain H with indexed mem", observed(), expect_of(2, 8'h74));

        // R8: lone prefix, second prefix held for next opcode
        put(8'hDD);
        put(8'hFD);
        chk("R8 lone prefix", observed(), expect_of(1, 8'hFD));
        put(8'hAC);
        chk("R8 second prefix applies", observed(), expect_of(2, 8'hAC));

        // R4: halt, sticky, reset clears
        chk1("R4 not halted yet", halted, 1'b0);
        put(8'hDD);
        put(8'h76);
        chk("R4 prefixed halt decode", observed(), expect_of(1, 8'h76));
        idle();
        chk1("R4 halted next cycle", halted, 1'b1);
        put(8'h00);
        idle();
        chk1("R4 halted sticky", halted, 1'b1);
        put(8'h41);
        chk("R9 prefix cleared by halt", observed(), expect_of(0, 8'h41));
        do_reset();
        chk1("R1 reset clears halted", halted, 1'b0);

        // exhaustive sweep: all opcodes under every prefix state
        for (int p = 0; p < 3; p++) begin
            for (int op = 0; op < 256; op++) begin
                if (p == 1) put(8'hDD);
                if (p == 2) put(8'hFD);
                put(8'(op));
                chk(tag_of(op), observed(), expect_of(p, op));
                if (op == 8'hDD || op == 8'hFD) begin
                    put(8'h00);
                    chk("R10 clears pending prefix", observed(), expect_of(0, 0));
                end
            end
        end
        idle();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule